// File: doc/BRIEF.md
# Sixteen-bit period timer with dual compare

This block is a 16-bit up-counting timer driven by a byte-oriented register port. Once enabled it counts from zero on every cycle in which the `tick` input is high. When the next count would reach the period held in compare register A, the counter returns to zero instead. On that tick it raises a one-cycle period pulse and a one-cycle compare-A pulse. A second compare register B raises its own one-cycle pulse when the counter lands on its value, and has no effect on the count sequence.

Software controls the timer through seven register locations. A two-byte control word sits at offsets 0x84 and 0x85. The low byte of that word, at 0x85, holds the run bit and the load bit. The other locations are the live counter (0xA4), two 8-bit compare-mode bytes (0xB4, 0xB5), and the two 16-bit compare values (0xC4, 0xD4). Each access is either one byte or two bytes wide. The block flags any access that is illegal in width, address or content, and a write flagged this way changes nothing.

Top module: `up_timer16`

## Requirements
- R1: After reset every register, including the counter, reads as zero and all three pulse outputs and the error output are low.
- R2: A written register reads back its value. A two-byte read at 0x84 returns the 0x84 byte in bits 15:8 and the 0x85 byte in bits 7:0. A one-byte write zero-extends into a 16-bit compare register. A one-byte read returns the low byte in bits 7:0 with bits 15:8 zero.
- R3: Two-byte accesses are legal only at 0x84, 0xA4 (read), 0xC4 and 0xD4. A two-byte access at 0x85, 0xB4 or 0xB5, or any access to an unlisted offset, raises `acc_err` for one cycle in the cycle after the access. Such a write updates nothing.
- R4: A write that sets bit 5, 3 or 2 of the 0x84 control byte is rejected with `acc_err`.
- R5: A write to the 0x85 control byte is rejected with `acc_err` if it sets bit 7 (run) and bit 6 (load) together, or sets any of bits 2:0.
- R6: The counter at 0xA4 is read-only. A write to it raises `acc_err` and leaves the count unchanged.
- R7: While run is set and compare A is nonzero, each tick adds one to the counter. If the incremented value would be equal to or greater than compare A, the counter becomes zero instead, and `period_pulse` and `cmpa_hit` are high for the following cycle.
- R8: `cmpb_hit` is high for one cycle after a tick that makes the counter equal compare B, including a wrap to zero when B is zero. The counter does not restart on this match.
- R9: With compare A equal to zero the timer does not count, even with run set, and the counter reads zero.
- R10: Clearing the run bit stops the counter and clears it to zero.
- R11: If compare A is lowered to a value at or below the next count while running, the next tick wraps the counter to zero with a period pulse.
- R12: While running, a cycle without `tick` leaves the counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Count enable, one count per high cycle |
| acc_wr | input | 1 | Register write strobe |
| acc_rd | input | 1 | Register read strobe |
| acc_addr | input | 8 | Register byte offset |
| acc_wide | input | 1 | 1 for a two-byte access, 0 for one byte |
| acc_wdata | input | 16 | Write data; a one-byte write uses bits 7:0 |
| acc_rdata | output | 16 | Read data, combinational from the address |
| acc_err | output | 1 | One-cycle flag for an illegal access |
| period_pulse | output | 1 | Counter wrapped at the compare-A period |
| cmpa_hit | output | 1 | Compare-A match pulse |
| cmpb_hit | output | 1 | Compare-B match pulse |

## Verification
The assertions assume that `acc_wr` and `acc_rd` are never high in the same cycle. They also assume that an access strobe lasts exactly one cycle and that `tick` is a clean level sampled on the rising edge. The stimulus holds to these assumptions: it changes every input on the falling edge and raises one strobe per access. The compare-B check assumes that compare B was not rewritten on the edge that produced the pulse. For this reason the bench never writes 0xD4 in a cycle that also carries a tick.

// File: rtl/up_timer16.sv
module up_timer16 #(
  parameter int          CW       = 16,
  parameter int          AW       = 8,
  parameter logic [AW-1:0] OFS_CTL_HI = 8'h84,
  parameter logic [AW-1:0] OFS_CTL_LO = 8'h85,
  parameter logic [AW-1:0] OFS_CNT    = 8'hA4,
  parameter logic [AW-1:0] OFS_MODA   = 8'hB4,
  parameter logic [AW-1:0] OFS_MODB   = 8'hB5,
  parameter logic [AW-1:0] OFS_CMPA   = 8'hC4,
  parameter logic [AW-1:0] OFS_CMPB   = 8'hD4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          acc_wr,
  input  logic          acc_rd,
  input  logic [AW-1:0] acc_addr,
  input  logic          acc_wide,
  input  logic [CW-1:0] acc_wdata,
  output logic [CW-1:0] acc_rdata,
  output logic          acc_err,
  output logic          period_pulse,
  output logic          cmpa_hit,
  output logic          cmpb_hit
);
  localparam int          BW      = CW / 2;
  localparam logic [BW-1:0] HI_RSV = 8'h2C;
  localparam logic [BW-1:0] LO_RSV = 8'h07;
  localparam int          RUN_BIT  = 7;
  localparam int          LOAD_BIT = 6;

  logic [BW-1:0] ctl_hi, ctl_lo, mod_a, mod_b;
  logic [CW-1:0] cmp_a, cmp_b, cnt;
  logic [CW:0]   nxt;
  logic          run, wr_bad, rd_bad;
  logic [BW-1:0] hi_byte, lo_byte;

  assign run     = ctl_lo[RUN_BIT] && (cmp_a != '0);
  assign nxt     = {1'b0, cnt} + 1'b1;
  assign hi_byte = acc_wide ? acc_wdata[CW-1:BW] : acc_wdata[BW-1:0];
  assign lo_byte = acc_wdata[BW-1:0];

  function automatic logic lo_ok(input logic [BW-1:0] v);
    return !(v[RUN_BIT] && v[LOAD_BIT]) && ((v & LO_RSV) == '0);
  endfunction

  always_comb begin
    wr_bad = 1'b0;
    case (acc_addr)
      OFS_CTL_HI: wr_bad = ((hi_byte & HI_RSV) != '0) || (acc_wide && !lo_ok(lo_byte));
      OFS_CTL_LO: wr_bad = acc_wide || !lo_ok(lo_byte);
      OFS_MODA, OFS_MODB: wr_bad = acc_wide;
      OFS_CMPA, OFS_CMPB: wr_bad = 1'b0;
      default: wr_bad = 1'b1;
    endcase
  end

  always_comb begin
    rd_bad    = 1'b0;
    acc_rdata = '0;
    case (acc_addr)
      OFS_CTL_HI: acc_rdata = acc_wide ? {ctl_hi, ctl_lo} : {{BW{1'b0}}, ctl_hi};
      OFS_CTL_LO: begin rd_bad = acc_wide; acc_rdata = {{BW{1'b0}}, ctl_lo}; end
      OFS_CNT:    acc_rdata = acc_wide ? cnt : {{BW{1'b0}}, cnt[BW-1:0]};
      OFS_MODA:   begin rd_bad = acc_wide; acc_rdata = {{BW{1'b0}}, mod_a}; end
      OFS_MODB:   begin rd_bad = acc_wide; acc_rdata = {{BW{1'b0}}, mod_b}; end
      OFS_CMPA:   acc_rdata = acc_wide ? cmp_a : {{BW{1'b0}}, cmp_a[BW-1:0]};
      OFS_CMPB:   acc_rdata = acc_wide ? cmp_b : {{BW{1'b0}}, cmp_b[BW-1:0]};
      default:    rd_bad = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_hi <= '0; ctl_lo <= '0; mod_a <= '0; mod_b <= '0;
      cmp_a <= '0; cmp_b <= '0; acc_err <= 1'b0;
    end else begin
      acc_err <= (acc_wr && wr_bad) || (acc_rd && rd_bad);
      if (acc_wr && !wr_bad) begin
        case (acc_addr)
          OFS_CTL_HI: begin
            ctl_hi <= hi_byte;
            if (acc_wide) ctl_lo <= lo_byte;
          end
          OFS_CTL_LO: ctl_lo <= lo_byte;
          OFS_MODA:   mod_a <= lo_byte;
          OFS_MODB:   mod_b <= lo_byte;
          OFS_CMPA:   cmp_a <= acc_wide ? acc_wdata : {{BW{1'b0}}, lo_byte};
          OFS_CMPB:   cmp_b <= acc_wide ? acc_wdata : {{BW{1'b0}}, lo_byte};
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; period_pulse <= 1'b0; cmpa_hit <= 1'b0; cmpb_hit <= 1'b0;
    end else begin
      period_pulse <= 1'b0;
      cmpa_hit     <= 1'b0;
      cmpb_hit     <= 1'b0;
      if (!run) begin
        cnt <= '0;
      end else if (tick) begin
        if (nxt >= {1'b0, cmp_a}) begin
          cnt          <= '0;
          period_pulse <= 1'b1;
          cmpa_hit     <= 1'b1;
          cmpb_hit     <= (cmp_b == '0);
        end else begin
          cnt      <= nxt[CW-1:0];
          cmpb_hit <= (nxt[CW-1:0] == cmp_b);
        end
      end
    end
  end

  p_stop_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));
  p_wrap_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    period_pulse |-> (cnt == '0 && cmpa_hit));
  p_step_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick) |=> (cnt == $past(cnt) + 1'b1 || cnt == '0));
  p_hold_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> (cnt == $past(cnt) || cnt == '0));
  p_b_value_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpb_hit && $stable(cmp_b)) |-> (cnt == cmp_b));
  p_no_pulse_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !period_pulse && !cmpa_hit && !cmpb_hit);
endmodule

// File: tb/test_up_timer16.sv
module test_up_timer16;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic        acc_wr = 1'b0, acc_rd = 1'b0, acc_wide = 1'b0;
  logic [7:0]  acc_addr = '0;
  logic [15:0] acc_wdata = '0, acc_rdata;
  logic        acc_err, period_pulse, cmpa_hit, cmpb_hit;
  int          n_run = 0, n_fail = 0;
  logic [15:0] rv;

  up_timer16 i_up_timer16 (.clk(clk), .rst_n(rst_n), .tick(tick), .acc_wr(acc_wr),
    .acc_rd(acc_rd), .acc_addr(acc_addr), .acc_wide(acc_wide), .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata), .acc_err(acc_err), .period_pulse(period_pulse),
    .cmpa_hit(cmpa_hit), .cmpb_hit(cmpb_hit));

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic [3:0]  rq;
    logic [7:0]  wa;
    logic        ww;
    logic [15:0] wd;
    logic        ee;
    logic [7:0]  ra;
    logic        rw;
    logic [15:0] rx;
  } vec_t;

  localparam vec_t VT [12] = '{
    '{4'd2, 8'hC4, 1'b1, 16'h1234, 1'b0, 8'hC4, 1'b1, 16'h1234}, // R2
    '{4'd2, 8'hD4, 1'b0, 16'h00AB, 1'b0, 8'hD4, 1'b1, 16'h00AB}, // R2
    '{4'd2, 8'hB4, 1'b0, 16'h005A, 1'b0, 8'hB4, 1'b0, 16'h005A}, // R2
    '{4'd2, 8'hB5, 1'b0, 16'h00C3, 1'b0, 8'hB5, 1'b0, 16'h00C3}, // R2
    '{4'd4, 8'h84, 1'b0, 16'h0024, 1'b1, 8'h84, 1'b0, 16'h0000}, // R4
    '{4'd5, 8'h85, 1'b0, 16'h00C0, 1'b1, 8'h85, 1'b0, 16'h0000}, // R5
    '{4'd5, 8'h85, 1'b0, 16'h0005, 1'b1, 8'h85, 1'b0, 16'h0000}, // R5
    '{4'd2, 8'h84, 1'b1, 16'h1140, 1'b0, 8'h84, 1'b1, 16'h1140}, // R2
    '{4'd3, 8'h85, 1'b1, 16'h0000, 1'b1, 8'h84, 1'b1, 16'h1140}, // R3
    '{4'd3, 8'hB4, 1'b1, 16'h7777, 1'b1, 8'hB4, 1'b0, 16'h005A}, // R3
    '{4'd6, 8'hA4, 1'b0, 16'h0009, 1'b1, 8'hA4, 1'b1, 16'h0000}, // R6
    '{4'd2, 8'hC4, 1'b0, 16'hFF07, 1'b0, 8'hC4, 1'b1, 16'h0007}  // R2
  };

  task automatic chk(input string rq, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic w, input logic [15:0] d);
    @(negedge clk);
    acc_wr = 1'b1; acc_addr = a; acc_wide = w; acc_wdata = d;
    @(negedge clk);
    acc_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic w, output logic [15:0] d);
    @(negedge clk);
    acc_rd = 1'b1; acc_addr = a; acc_wide = w;
    #1 d = acc_rdata;
    @(negedge clk);
    acc_rd = 1'b0;
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 pulses", {13'd0, period_pulse, cmpa_hit, cmpb_hit}, 16'h0);
    chk("R1 err", {15'd0, acc_err}, 16'h0);
    rst_n = 1'b1;
    foreach (VT[i]) begin
      rd(VT[i].ra, 1'b1 & (VT[i].ra != 8'h85 && VT[i].ra != 8'hB4 && VT[i].ra != 8'hB5), rv);
      chk("R1 reg", rv, 16'h0);
    end

    // table: write, check error flag, read back
    foreach (VT[i]) begin
      wr(VT[i].wa, VT[i].ww, VT[i].wd);
      n_run++;
      if (acc_err !== VT[i].ee) begin
        n_fail++;
        $display("FAIL R%0d row %0d err actual=%b expected=%b", VT[i].rq, i, acc_err, VT[i].ee);
      end
      rd(VT[i].ra, VT[i].rw, rv);
      n_run++;
      if (rv !== VT[i].rx) begin
        n_fail++;
        $display("FAIL R%0d row %0d read actual=%h expected=%h", VT[i].rq, i, rv, VT[i].rx);
      end
    end

    // R3: unknown offset, and illegal wide read
    wr(8'h10, 1'b0, 16'h1);
    chk("R3 bad addr", {15'd0, acc_err}, 16'h1);
    rd(8'hB5, 1'b1, rv);
    chk("R3 wide read", {15'd0, acc_err}, 16'h1);

    // R7 and R8: period 3, compare B 2
    wr(8'hC4, 1'b1, 16'h0003);
    wr(8'hD4, 1'b0, 16'h0002);
    wr(8'h85, 1'b0, 16'h0080);
    rd(8'hA4, 1'b1, rv); chk("R7 start", rv, 16'h0);
    do_tick();
    chk("R7 t1 pulses", {13'd0, period_pulse, cmpa_hit, cmpb_hit}, 16'h0);
    rd(8'hA4, 1'b1, rv); chk("R7 t1 count", rv, 16'h1);
    do_tick();
    chk("R8 b hit", {13'd0, period_pulse, cmpa_hit, cmpb_hit}, 16'h1);
    rd(8'hA4, 1'b1, rv); chk("R8 no restart", rv, 16'h2);
    do_tick();
    chk("R7 wrap pulses", {13'd0, period_pulse, cmpa_hit, cmpb_hit}, 16'h6);
    rd(8'hA4, 1'b1, rv); chk("R7 wrap count", rv, 16'h0);

    // R12: hold without tick
    do_tick();
    repeat (4) @(negedge clk);
    rd(8'hA4, 1'b1, rv); chk("R12 hold", rv, 16'h1);

    // R11: lower period below next count
    wr(8'hC4, 1'b1, 16'h0001);
    do_tick();
    chk("R11 early wrap", {13'd0, period_pulse, cmpa_hit, 1'b0}, 16'h6);
    rd(8'hA4, 1'b1, rv); chk("R11 count", rv, 16'h0);

    // R6: counter write ignored while running
    wr(8'hC4, 1'b1, 16'h0009);
    do_tick(); do_tick();
    wr(8'hA4, 1'b1, 16'h0077);
    chk("R6 err", {15'd0, acc_err}, 16'h1);
    rd(8'hA4, 1'b1, rv); chk("R6 count kept", rv, 16'h2);

    // R10: disable clears
    wr(8'h85, 1'b0, 16'h0000);
    rd(8'hA4, 1'b1, rv); chk("R10 cleared", rv, 16'h0);

    // R9: zero period does not count
    wr(8'hC4, 1'b1, 16'h0000);
    wr(8'h85, 1'b0, 16'h0080);
    do_tick();
    chk("R9 no pulse", {13'd0, period_pulse, cmpa_hit, cmpb_hit}, 16'h0);
    do_tick();
    rd(8'hA4, 1'b1, rv); chk("R9 zero", rv, 16'h0);

    // R8: compare B zero fires on wrap
    wr(8'hD4, 1'b1, 16'h0000);
    wr(8'hC4, 1'b1, 16'h0002);
    do_tick();
    chk("R8 b0 no hit", {13'd0, period_pulse, cmpa_hit, cmpb_hit}, 16'h0);
    do_tick();
    chk("R8 b0 wrap hit", {13'd0, period_pulse, cmpa_hit, cmpb_hit}, 16'h7);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule